// File: doc/BRIEF.md
# CW Keying Envelope Shaper

This block turns a Morse key level into a shaped transmit carrier at a 50 kHz intermediate frequency, one sample per sample strobe at a 192 kHz rate. When the key goes down, the carrier amplitude climbs from silence to full scale along a raised-cosine curve lasting 960 samples (5 ms). When the key comes up, the amplitude falls along the mirror image of that curve over the same span. Between ramps the carrier is either at full amplitude or exactly zero. The soft edges keep keying clicks out of the neighbouring spectrum.

A numerically controlled oscillator makes the carrier. It advances 25/96 of a cycle on every accepted sample, so 50 kHz at 192 kHz is exact and the waveform repeats every 96 samples. The oscillator runs whether or not the key is down, so a new key-down picks up the carrier at whatever phase it has reached. If the key changes while a ramp is in progress, the envelope turns back from its current height instead of restarting, so the amplitude never jumps.

The sample strobe is the input side of a valid/ready stream. The shaped sample is its output side. The block holds one output sample. It accepts a strobe only when that slot is empty or is being emptied in the same cycle. While the consumer holds `out_ready` low, the pending sample stays frozen and new strobes wait. The key level is read only on the cycle a strobe is accepted.

Top module: `cw_envelope_shaper`

## Requirements
- R1: `in_ready` is high exactly when no output sample is pending or the pending one is taken in the same cycle. Each accepted strobe produces exactly one output sample, with `out_valid` high from the next cycle on. The key is sampled only on accepted strobes.
- R2: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_sample` keeps its value.
- R3: After reset no sample is pending, `in_ready` is high, the envelope is idle and the carrier phase index is 0.
- R4: Once the envelope has returned to idle, every output sample is exactly 0.
- R5: The carrier phase index p (0..95) starts at 0 and advances by 25 modulo 96 on every accepted strobe, whatever the key level. Each sample uses C(p) = round(32767·sin(2πp/96)), taken before the phase advances.
- R6: With the envelope idle, a key-down strobe starts a rise. Rise samples use envelope E(k) for k = 0..959, where E(k) = round(32768·0.5·(1−cos(πk/960))). Every later key-down sample uses the full envelope 32768.
- R7: With the envelope at full, a key-up strobe starts a fall. The fall uses E(959−j) for j = 0..959, and the block then returns to idle.
- R8: A key-up strobe during a rise whose last envelope was E(k) gives E(k−1) next, and the fall continues downward from there. If k was 0, the block returns straight to idle.
- R9: A key-down strobe during a fall whose last envelope was E(m) gives E(m+1) next, and the rise continues upward from there. If m was 959, the block returns straight to full.
- R10: Each output sample is floor((C·E + 16384) / 32768) as a signed 16-bit value. At full envelope this equals C exactly.
- R11: Between consecutive accepted strobes the envelope changes by no more than (2·32768)/960 + 2 codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_down | input | 1 | Key level, 1 = carrier requested |
| in_valid | input | 1 | Sample strobe (stream valid) |
| in_ready | output | 1 | Strobe accepted when high with `in_valid` |
| out_valid | output | 1 | Shaped sample pending |
| out_ready | input | 1 | Consumer takes the pending sample |
| out_sample | output | 16 | Signed shaped carrier sample |

## Verification
A wrong ramp index or ramp state shows up at once as an amplitude off the raised-cosine curve. A wrong reversal index appears on the first sample after a mid-ramp key change, as a repeated or skipped envelope step. The sample-by-sample scoreboard and the step-size property catch both within one sample. A carrier phase that has drifted corrupts every nonzero sample from that point on and never heals. An idle state that leaks carrier, or a back-pressure slip that drops or duplicates a sample, misaligns the whole queue from the cycle it happens. Stimulus covers reversals at index 0, at the ramp ends, in the middle of ramps, and under random back-pressure.

// File: rtl/cwshape_pkg.sv
package cwshape_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RISE = 2'd1,
    ST_ON   = 2'd2,
    ST_FALL = 2'd3
  } ramp_state_e;

  localparam real PI_R = 3.141592653589793;

  // Raised-cosine envelope point n of a ramp of len steps, scaled to full.
  function automatic int ramp_entry(input int n, input int len, input int full);
    real x;
    x = 0.5 * (1.0 - $cos(PI_R * n / len));
    return $rtoi($floor(x * full + 0.5));
  endfunction

  // Sine sample at phase index p of a den-point cycle, amplitude amp.
  function automatic int sine_entry(input int p, input int den, input int amp);
    real x;
    x = amp * $sin(2.0 * PI_R * p / den);
    return $rtoi($floor(x + 0.5));
  endfunction

endpackage

// File: rtl/cw_ramp_ctrl.sv
module cw_ramp_ctrl
  import cwshape_pkg::*;
#(
  parameter int RAMP_LEN = 960,
  localparam int IDX_W = $clog2(RAMP_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             key,
  output ramp_state_e      state_d,
  output logic [IDX_W-1:0] idx_d
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(RAMP_LEN - 1);
  localparam logic [IDX_W-1:0] SPAN = IDX_W'(RAMP_LEN);

  ramp_state_e      state_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (key) begin
          state_d = ST_RISE;
          idx_d   = '0;
        end
      end
      ST_RISE: begin
        if (key) begin
          if (idx_q == LAST) begin
            state_d = ST_ON;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if (idx_q == '0) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_FALL;
          idx_d   = SPAN - idx_q;
        end
      end
      ST_ON: begin
        if (!key) begin
          state_d = ST_FALL;
          idx_d   = '0;
        end
      end
      ST_FALL: begin
        if (!key) begin
          if (idx_q == LAST) begin
            state_d = ST_IDLE;
            idx_d   = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end else if (idx_q == '0) begin
          state_d = ST_ON;
        end else begin
          state_d = ST_RISE;
          idx_d   = SPAN - idx_q;
        end
      end
      default: begin
        state_d = ST_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (adv) begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/cw_env_rom.sv
module cw_env_rom
  import cwshape_pkg::*;
#(
  parameter int RAMP_LEN = 960,
  parameter int ENV_FRAC = 15,
  localparam int IDX_W = $clog2(RAMP_LEN + 1),
  localparam int ENV_W = ENV_FRAC + 1
) (
  input  ramp_state_e      state,
  input  logic [IDX_W-1:0] idx,
  output logic [ENV_W-1:0] env
);

  localparam int FULL = 1 << ENV_FRAC;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(RAMP_LEN - 1);

  logic [ENV_W-1:0] tbl [RAMP_LEN];
  logic [IDX_W-1:0] lvl;

  for (genvar i = 0; i < RAMP_LEN; i++) begin : g_tbl
    assign tbl[i] = ENV_W'(ramp_entry(i, RAMP_LEN, FULL));
  end

  // The fall reads the rise curve backwards.
  assign lvl = (state == ST_FALL) ? (LAST - idx) : idx;

  always_comb begin
    unique case (state)
      ST_IDLE: env = '0;
      ST_ON:   env = ENV_W'(FULL);
      default: env = tbl[lvl];
    endcase
  end

endmodule

// File: rtl/cw_nco.sv
module cw_nco
  import cwshape_pkg::*;
#(
  parameter int CAR_NUM = 25,
  parameter int CAR_DEN = 96,
  parameter int SMP_W   = 16,
  localparam int PH_W = $clog2(CAR_DEN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic signed [SMP_W-1:0] carrier
);

  localparam int AMP = (1 << (SMP_W - 1)) - 1;
  localparam logic [PH_W:0] STEP = (PH_W + 1)'(CAR_NUM);
  localparam logic [PH_W:0] WRAP = (PH_W + 1)'(CAR_DEN);

  logic signed [SMP_W-1:0] wave [CAR_DEN];
  logic [PH_W-1:0] phase_q;
  logic [PH_W:0]   sum;

  for (genvar p = 0; p < CAR_DEN; p++) begin : g_wave
    assign wave[p] = SMP_W'(sine_entry(p, CAR_DEN, AMP));
  end

  assign sum     = {1'b0, phase_q} + STEP;
  assign carrier = wave[phase_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (adv) begin
      phase_q <= (sum >= WRAP) ? PH_W'(sum - WRAP) : PH_W'(sum);
    end
  end

endmodule

// File: rtl/cw_mixer.sv
module cw_mixer #(
  parameter int SMP_W    = 16,
  parameter int ENV_FRAC = 15,
  localparam int ENV_W  = ENV_FRAC + 1,
  localparam int PROD_W = SMP_W + ENV_W + 1
) (
  input  logic signed [SMP_W-1:0] carrier,
  input  logic [ENV_W-1:0]        env,
  output logic signed [SMP_W-1:0] product
);

  localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) <<< (ENV_FRAC - 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] sum;
  logic unused_bits;

  assign prod        = PROD_W'(carrier) * $signed({1'b0, env});
  assign sum         = prod + HALF;
  assign product     = sum[ENV_FRAC +: SMP_W];
  assign unused_bits = ^{sum[ENV_FRAC-1:0], sum[PROD_W-1:ENV_FRAC+SMP_W]};

endmodule

// File: rtl/cw_envelope_shaper.sv
module cw_envelope_shaper
  import cwshape_pkg::*;
#(
  parameter int RAMP_LEN = 960,
  parameter int CAR_NUM  = 25,
  parameter int CAR_DEN  = 96,
  parameter int SMP_W    = 16,
  parameter int ENV_FRAC = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    key_down,
  input  logic                    in_valid,
  output logic                    in_ready,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [SMP_W-1:0] out_sample
);

  localparam int IDX_W = $clog2(RAMP_LEN + 1);
  localparam int ENV_W = ENV_FRAC + 1;

  logic                    adv;
  ramp_state_e             state_d;
  logic [IDX_W-1:0]        idx_d;
  logic [ENV_W-1:0]        env_lvl;
  logic signed [SMP_W-1:0] carrier;
  logic signed [SMP_W-1:0] mixed;

  assign in_ready = !out_valid || out_ready;
  assign adv      = in_valid && in_ready;

  cw_ramp_ctrl #(.RAMP_LEN(RAMP_LEN)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .key     (key_down),
    .state_d (state_d),
    .idx_d   (idx_d)
  );

  cw_env_rom #(.RAMP_LEN(RAMP_LEN), .ENV_FRAC(ENV_FRAC)) u_rom (
    .state (state_d),
    .idx   (idx_d),
    .env   (env_lvl)
  );

  cw_nco #(.CAR_NUM(CAR_NUM), .CAR_DEN(CAR_DEN), .SMP_W(SMP_W)) u_nco (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .carrier (carrier)
  );

  cw_mixer #(.SMP_W(SMP_W), .ENV_FRAC(ENV_FRAC)) u_mix (
    .carrier (carrier),
    .env     (env_lvl),
    .product (mixed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else if (adv) begin
      out_valid  <= 1'b1;
      out_sample <= mixed;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end

endmodule

// File: rtl/cw_envelope_shaper_chk.sv
module cw_envelope_shaper_chk
  import cwshape_pkg::*;
#(
  parameter int RAMP_LEN = 960,
  parameter int SMP_W    = 16,
  parameter int ENV_FRAC = 15,
  localparam int ENV_W = ENV_FRAC + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic signed [SMP_W-1:0] out_sample,
  input ramp_state_e             state_d,
  input logic [ENV_W-1:0]        env_now
);

  localparam int FULL     = 1 << ENV_FRAC;
  localparam int MAX_STEP = (2 * FULL) / RAMP_LEN + 2;

  logic           acc;
  logic [ENV_W-1:0] env_prev;
  int             step_abs;

  assign acc      = in_valid && in_ready;
  assign step_abs = (int'(env_now) >= int'(env_prev)) ? int'(env_now) - int'(env_prev)
                                                      : int'(env_prev) - int'(env_now);

  always_ff @(posedge clk) begin
    if (!rst_n) env_prev <= '0;
    else if (acc) env_prev <= env_now;
  end

  a_r1_accept_gives_output: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r2_hold_under_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_sample));

  a_r3_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  a_r4_idle_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    acc && state_d == ST_IDLE |=> out_sample == '0);

  a_r6_full_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    acc && state_d == ST_ON |-> env_now == ENV_W'(FULL));

  a_r11_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> step_abs <= MAX_STEP);

endmodule

bind cw_envelope_shaper cw_envelope_shaper_chk #(
  .RAMP_LEN (RAMP_LEN),
  .SMP_W    (SMP_W),
  .ENV_FRAC (ENV_FRAC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_sample (out_sample),
  .state_d    (state_d),
  .env_now    (env_lvl)
);

// File: tb/cw_envelope_shaper_test.sv
`timescale 1ns/1ps
module cw_envelope_shaper_test;

  localparam int RAMP = 960;
  localparam int NUM  = 25;
  localparam int DEN  = 96;
  localparam real PI  = 3.141592653589793;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic key_down = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [15:0] out_sample;

  always #2 clk = ~clk;

  cw_envelope_shaper uut (
    .clk(clk), .rst_n(rst_n), .key_down(key_down), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample)
  );

  typedef struct { int val; string tag; } exp_t;
  exp_t sb[$];

  int checks = 0;
  int fails  = 0;
  bit bp_mode = 1'b0;
  bit done = 1'b0;

  // Reference model state, built from the requirements
  int m_st = 0;   // 0 idle, 1 rise, 2 on, 3 fall
  int m_k  = 0;
  int m_ph = 0;

  function automatic int env_e(input int k);
    return $rtoi($floor(32768.0 * 0.5 * (1.0 - $cos(PI * k / RAMP)) + 0.5));
  endfunction

  function automatic int car_c(input int p);
    return $rtoi($floor(32767.0 * $sin(2.0 * PI * p / DEN) + 0.5));
  endfunction

  function automatic void check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endfunction

  // Advance the model by one accepted strobe; returns expected sample and tag
  function automatic exp_t model_step(input bit k);
    exp_t e;
    int env;
    string tag;
    tag = "R5";
    case (m_st)
      0: if (k) begin m_st = 1; m_k = 0; tag = "R6"; end else tag = "R4";
      1: if (k) begin
           tag = "R6";
           if (m_k == RAMP - 1) begin m_st = 2; m_k = 0; end else m_k++;
         end else begin
           tag = "R8";
           if (m_k == 0) m_st = 0; else begin m_st = 3; m_k = RAMP - m_k; end
         end
      2: if (!k) begin m_st = 3; m_k = 0; tag = "R7"; end else tag = "R10";
      default: if (!k) begin
           tag = "R7";
           if (m_k == RAMP - 1) begin m_st = 0; m_k = 0; end else m_k++;
         end else begin
           tag = "R9";
           if (m_k == 0) m_st = 2; else begin m_st = 1; m_k = RAMP - m_k; end
         end
    endcase
    case (m_st)
      0: env = 0;
      1: env = env_e(m_k);
      2: env = 32768;
      default: env = env_e(RAMP - 1 - m_k);
    endcase
    e.val = (car_c(m_ph) * env + 16384) >>> 15;
    e.tag = tag;
    m_ph = (m_ph + NUM) % DEN;
    return e;
  endfunction

  function automatic bit pick_ready();
    return bp_mode ? ($urandom % 3 != 0) : 1'b1;
  endfunction

  // Driver: offer one strobe with key level k, then gap idle cycles
  task automatic send(input bit k, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    key_down = k;
    out_ready = pick_ready();
    #1;
    while (!in_ready) begin
      @(negedge clk);
      out_ready = pick_ready();
      #1;
    end
    sb.push_back(model_step(k));
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
      key_down = ~k;   // key changes without a strobe are ignored (R1)
      out_ready = pick_ready();
    end
    if (gap > 0) begin
      @(negedge clk);
      key_down = k;
    end
  endtask

  task automatic run(input bit k, input int n, input int gap);
    for (int i = 0; i < n; i++) send(k, gap);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && !done) begin
        check(in_ready == (!out_valid || out_ready), "R1", int'(in_ready),
              int'(!out_valid || out_ready));
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check(1'b0, "R1", int'(out_sample), 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(int'(out_sample) == e.val, e.tag, int'(out_sample), e.val);
          end
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R3", int'(out_valid), 0);
        check(in_ready == 1'b1, "R3", int'(in_ready), 1);
        // Idle with key up: silent output, phase still running (R4, R5)
        run(1'b0, 20, 0);
        // Full rise, hold, full fall (R6, R7, R10)
        run(1'b1, 1100, 0);
        run(1'b0, 1000, 0);
        // Mid-ramp reversals under back-pressure and strobe gaps (R2, R8, R9)
        bp_mode = 1'b1;
        run(1'b1, 300, 0);
        run(1'b0, 100, 1);
        run(1'b1, 250, 0);
        run(1'b1, 800, 0);
        run(1'b0, 500, 0);
        run(1'b1, 40, 2);
        run(1'b0, 1000, 0);
        // Reversal at index 0 of a rise, and at index 0 of a fall
        bp_mode = 1'b0;
        run(1'b1, 1, 0);
        run(1'b0, 5, 0);
        run(1'b1, 1000, 0);
        run(1'b0, 1, 0);
        run(1'b1, 5, 0);
        // Reversal at the last point of a fall
        run(1'b0, 960, 0);
        run(1'b1, 3, 0);
        run(1'b0, 980, 0);
        run(1'b0, 10, 0);
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R1", sb.size(), 0);
      end
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule